// File: doc/BRIEF.md
# Dual-Source Multiplexing Latch Bank

A bank of independent storage lanes. Each lane sees two data sources and selects or combines them through one select code shared by all lanes. It stores the result and drives a true output and an inverted output. The block is the clocked form of a transparent latch. On a rising clock edge at which both active-low enables are asserted, every lane loads the function of its sources that the select code picks. If either enable is deasserted, every lane keeps its stored value.

The block has two ways to clear the stored value, and both act at once without waiting for a clock. The first is the chip reset `rst_ni`, which is active low. The second is a functional clear `clr_i`, which is active high. The clear overrides the load condition: while it is high, no enable or select pattern can set a lane. The select code also works as a plain 2:1 steering choice when its two bits are driven together.

Top module: `mlb_bank`

## Requirements
- R1: While `rst_ni` is low, every `q_o` bit is 0. The clear takes effect without waiting for a clock edge.
- R2: While `clr_i` is high, every `q_o` bit is 0. The clear takes effect without a clock edge and overrides a load in the same cycle.
- R3: A lane loads only at a rising clock edge where `en1_ni`, `en2_ni` and `clr_i` are all sampled low.
- R4: At an edge where either `en1_ni` or `en2_ni` is high, `q_o` keeps its value, whatever the data and select inputs are.
- R5: Select code `sel_i` = 2'b00 loads `d0_i` of each lane.
- R6: Select code `sel_i` = 2'b11 loads `d1_i` of each lane.
- R7: Select code `sel_i` = 2'b10 loads the bitwise OR of `d0_i` and `d1_i`.
- R8: Select code `sel_i` = 2'b01 loads 0 into every lane, regardless of the data inputs.
- R9: `qn_o` is the bitwise inverse of `q_o` at all times, including during clear and hold.
- R10: After a clear is released, `q_o` stays 0 until the first load edge.
- R11: Lanes are independent. Bit slice k of `d0_i` and `d1_i` drives only bit slice k of `q_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous chip reset, active low |
| clr_i | input | 1 | Asynchronous functional clear, active high |
| en1_ni | input | 1 | First load enable, active low |
| en2_ni | input | 1 | Second load enable, active low |
| sel_i | input | 2 | Lane function code |
| d0_i | input | LANES*LANE_W | First source, lane k in slice k |
| d1_i | input | LANES*LANE_W | Second source, lane k in slice k |
| q_o | output | LANES*LANE_W | Stored lane values |
| qn_o | output | LANES*LANE_W | Inverse of q_o |

## Verification
The bench builds the block with four lanes of one bit each, so each 4-bit vector holds a different pattern per lane. This lets one check show that the lanes are independent, and that OR mode differs from both pass modes in the same load. Holding either enable high while the data and select inputs change shows that nothing leaks through a hold. Pulsing each clear between clock edges shows that it acts at once, and keeping the clear high across a load edge shows that it wins over the load.

// File: rtl/mlb_pkg.sv
package mlb_pkg;
  typedef enum logic [1:0] {
    SEL_PASS0 = 2'b00,
    SEL_ZERO  = 2'b01,
    SEL_OR    = 2'b10,
    SEL_PASS1 = 2'b11
  } sel_mode_e;
endpackage

// File: rtl/mlb_enable.sv
module mlb_enable (
  input  logic en1_ni,
  input  logic en2_ni,
  output logic load_o
);
  assign load_o = ~en1_ni & ~en2_ni;
endmodule

// File: rtl/mlb_lane_mux.sv
module mlb_lane_mux
  import mlb_pkg::*;
#(
  parameter int unsigned W = 1
) (
  input  sel_mode_e      sel_i,
  input  logic [W-1:0]   d0_i,
  input  logic [W-1:0]   d1_i,
  output logic [W-1:0]   y_o
);
  always_comb begin
    unique case (sel_i)
      SEL_PASS0: y_o = d0_i;
      SEL_PASS1: y_o = d1_i;
      SEL_OR:    y_o = d0_i | d1_i;
      default:   y_o = '0;
    endcase
  end
endmodule

// File: rtl/mlb_lane_reg.sv
module mlb_lane_reg #(
  parameter int unsigned W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  // both clears asynchronous; clear beats load
  always_ff @(posedge clk_i or negedge rst_ni or posedge clr_i) begin
    if (!rst_ni || clr_i) q_o <= '0;
    else if (load_i)      q_o <= d_i;
  end
endmodule

// File: rtl/mlb_bank.sv
module mlb_bank
  import mlb_pkg::*;
#(
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 1,
  localparam int unsigned TOT_W = LANES * LANE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en1_ni,
  input  logic             en2_ni,
  input  logic [1:0]       sel_i,
  input  logic [TOT_W-1:0] d0_i,
  input  logic [TOT_W-1:0] d1_i,
  output logic [TOT_W-1:0] q_o,
  output logic [TOT_W-1:0] qn_o
);
  logic      load;
  sel_mode_e mode;

  assign mode = sel_mode_e'(sel_i);

  mlb_enable u_enable (
    .en1_ni (en1_ni),
    .en2_ni (en2_ni),
    .load_o (load)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [LANE_W-1:0] nxt;

    mlb_lane_mux #(.W(LANE_W)) u_mux (
      .sel_i (mode),
      .d0_i  (d0_i[k*LANE_W +: LANE_W]),
      .d1_i  (d1_i[k*LANE_W +: LANE_W]),
      .y_o   (nxt)
    );

    mlb_lane_reg #(.W(LANE_W)) u_reg (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (clr_i),
      .load_i (load),
      .d_i    (nxt),
      .q_o    (q_o[k*LANE_W +: LANE_W])
    );
  end

  assign qn_o = ~q_o;
endmodule

// File: rtl/mlb_bank_chk.sv
module mlb_bank_chk #(
  parameter int unsigned TOT_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             clr_i,
  input logic             en1_ni,
  input logic             en2_ni,
  input logic [1:0]       sel_i,
  input logic [TOT_W-1:0] d0_i,
  input logic [TOT_W-1:0] d1_i,
  input logic [TOT_W-1:0] q_o,
  input logic [TOT_W-1:0] qn_o
);
  a_r9_complement: assert property (@(posedge clk_i) disable iff (!rst_ni)
    qn_o == ~q_o);

  a_r2_clear_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |-> q_o == '0);

  a_r4_hold: assert property (@(posedge clk_i) disable iff (!rst_ni || clr_i)
    (en1_ni || en2_ni) |=> $stable(q_o));

  a_r5_pass0: assert property (@(posedge clk_i) disable iff (!rst_ni || clr_i)
    (!en1_ni && !en2_ni && sel_i == 2'b00) |=> q_o == $past(d0_i));

  a_r6_pass1: assert property (@(posedge clk_i) disable iff (!rst_ni || clr_i)
    (!en1_ni && !en2_ni && sel_i == 2'b11) |=> q_o == $past(d1_i));

  a_r7_or: assert property (@(posedge clk_i) disable iff (!rst_ni || clr_i)
    (!en1_ni && !en2_ni && sel_i == 2'b10) |=> q_o == ($past(d0_i) | $past(d1_i)));

  a_r8_zero: assert property (@(posedge clk_i) disable iff (!rst_ni || clr_i)
    (!en1_ni && !en2_ni && sel_i == 2'b01) |=> q_o == '0);

  a_r10_stay_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && (en1_ni || en2_ni)) |=> (en1_ni || en2_ni || clr_i) |-> q_o == '0);
endmodule

bind mlb_bank mlb_bank_chk #(.TOT_W(TOT_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .clr_i  (clr_i),
  .en1_ni (en1_ni),
  .en2_ni (en2_ni),
  .sel_i  (sel_i),
  .d0_i   (d0_i),
  .d1_i   (d1_i),
  .q_o    (q_o),
  .qn_o   (qn_o)
);

// File: tb/tb_mlb_bank.sv
module tb_mlb_bank;
  localparam int unsigned LANES = 4;
  localparam int unsigned LANE_W = 1;
  localparam int unsigned W = LANES * LANE_W;
  localparam int unsigned NVEC = 12;

  // {en1_n, en2_n, sel[1:0], d0[3:0], d1[3:0], expected q[3:0]}
  localparam logic [15:0] VEC [NVEC] = '{
    16'b0_0_00_1010_0101_1010, // R5
    16'b0_0_11_1010_0101_0101, // R6
    16'b0_0_10_1100_0011_1111, // R7
    16'b0_0_10_1000_0000_1000, // R7
    16'b0_0_01_1111_1111_0000, // R8
    16'b0_0_00_0110_1001_0110, // R5
    16'b1_0_11_1111_0000_0110, // R4
    16'b0_1_00_0000_0000_0110, // R4
    16'b1_1_01_1111_1111_0110, // R4
    16'b0_0_11_0000_1011_1011, // R11
    16'b0_0_10_0001_0000_0001, // R11
    16'b0_0_00_0000_0000_0000  // R3
  };

  logic clk_i = 1'b0;
  logic rst_ni, clr_i, en1_ni, en2_ni;
  logic [1:0] sel_i;
  logic [W-1:0] d0_i, d1_i, q_o, qn_o;
  int n_chk = 0;
  int n_fail = 0;

  always #10 clk_i = ~clk_i;

  mlb_bank #(.LANES(LANES), .LANE_W(LANE_W)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_i), .en1_ni(en1_ni),
    .en2_ni(en2_ni), .sel_i(sel_i), .d0_i(d0_i), .d1_i(d1_i),
    .q_o(q_o), .qn_o(qn_o)
  );

  task automatic check(input string tag, input logic [W-1:0] exp);
    n_chk++;
    if (q_o !== exp) begin
      n_fail++;
      $display("FAIL %s q_o=%b expected %b", tag, q_o, exp);
    end
    n_chk++;
    if (qn_o !== ~exp) begin
      n_fail++;
      $display("FAIL R9 qn_o=%b expected %b", qn_o, ~exp);
    end
  endtask

  task automatic drive(input logic e1, input logic e2, input logic [1:0] s,
                       input logic [W-1:0] a, input logic [W-1:0] b);
    en1_ni = e1; en2_ni = e2; sel_i = s; d0_i = a; d1_i = b;
  endtask

  initial begin
    rst_ni = 1'b0; clr_i = 1'b0;
    drive(1'b0, 1'b0, 2'b00, 4'b1111, 4'b1111);
    repeat (2) @(negedge clk_i);
    check("R1", 4'b0000);
    rst_ni = 1'b1;
    drive(1'b1, 1'b1, 2'b00, '0, '0);
    @(negedge clk_i);

    for (int i = 0; i < NVEC; i++) begin
      drive(VEC[i][15], VEC[i][14], VEC[i][13:12], VEC[i][11:8], VEC[i][7:4]);
      @(negedge clk_i);
      check($sformatf("R3-vec%0d", i), VEC[i][3:0]);
    end

    // R1: reset acts between edges
    drive(1'b0, 1'b0, 2'b00, 4'b1101, 4'b0000);
    @(negedge clk_i);
    check("R5", 4'b1101);
    drive(1'b1, 1'b1, 2'b00, 4'b1101, 4'b0000);
    rst_ni = 1'b0;
    #1;
    check("R1", 4'b0000);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R2: clear acts between edges and beats a load
    drive(1'b0, 1'b0, 2'b11, 4'b0000, 4'b0111);
    @(negedge clk_i);
    check("R6", 4'b0111);
    drive(1'b0, 1'b0, 2'b00, 4'b1111, 4'b0000);
    clr_i = 1'b1;
    #1;
    check("R2", 4'b0000);
    @(negedge clk_i);
    check("R2", 4'b0000);

    // R10: after release, held enables keep zero
    drive(1'b1, 1'b0, 2'b00, 4'b1111, 4'b0000);
    clr_i = 1'b0;
    @(negedge clk_i);
    check("R10", 4'b0000);
    drive(1'b0, 1'b1, 2'b11, 4'b1111, 4'b1111);
    @(negedge clk_i);
    check("R10", 4'b0000);
    drive(1'b0, 1'b0, 2'b10, 4'b1001, 4'b0100);
    @(negedge clk_i);
    check("R7", 4'b1101);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog q_o=%b expected run end", q_o);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule